// File: doc/BRIEF.md
# System-Management Memory Access Router

This block sits between a processor's memory requests and the rest of the chipset, and decides, one request at a time, where a 32-bit physical address is delivered. Every request carries a flag that marks it as issued in system-management mode (SMM) or in normal mode. The block sends it to DRAM at a translated address, to the PCI/VGA side, or to a blackhole that returns all ones and silently drops writes. The decision comes out one clock after the request.

Firmware sets up the block through a byte-wide configuration port with two 8-bit control registers. The legacy register opens the protected window to normal code, enables it globally, and locks the setup. The extended register moves the protected area from the legacy VGA hole to a high alias, and reserves a segment just under the top of low memory. After the lock bit is written, the open bit is dropped at once and both registers refuse further writes until reset.

Three windows are decoded: a low window of 128 KiB at 0xA0000, a high alias of 128 KiB at 0xFEDA0000 that reaches the same DRAM bytes as the low one, and a segment of 1, 2 or 8 MiB that ends at the top of low memory. Addresses outside the windows go to DRAM below the top of low memory and to PCI above it.

Top module: `smm_mem_router`

## Requirements
- R1: After reset both control registers read 0x00, and `outValid` is 0 until a request is accepted.
- R2: Legacy register (`cfgSel`=0): bit 0 = open, bit 1 = lock, bit 2 = global enable. Extended register (`cfgSel`=1): bit 0 = high select, bits 2:1 = segment size code, bit 3 = segment enable. While unlocked every defined bit is writable. Undefined bits always read 0.
- R3: A legacy write that sets the lock bit clears the open bit in the same write. From then on, writes to either register leave it unchanged until reset.
- R4: Normal mode, low window 0xA0000–0xBFFFF: route 0 (DRAM, same address) when open=1 and high select=0; otherwise route 1 (PCI).
- R5: Normal mode, high window 0xFEDA0000–0xFEDBFFFF: route 0 with address `addr - 0xFEDA0000 + 0xA0000` when open=1 and high select=1; otherwise it is decoded as an ordinary address (R9).
- R6: SMM mode: the low window goes to DRAM at the same address when high select=0 and (global enable or open) is 1, else to PCI. The high window goes to DRAM, translated as in R5, when high select=1 and (global enable or open) is 1, else it is decoded per R9.
- R7: Segment size: 0 when the segment enable is 0. Otherwise code 0 = 1 MiB, 1 = 2 MiB, 2 = 8 MiB, 3 = 0.
- R8: The segment is [TOP_LOW − size, TOP_LOW). Normal-mode requests there get route 2 (blackhole) with `outData` = 0xFFFFFFFF. SMM requests there get route 0 at the same address.
- R9: Any other address goes to route 0 at the same address when below TOP_LOW (default 0x80000000), else to route 1. `outData` is 0 on every route except 2.
- R10: Each request appears on the outputs exactly one clock after it is presented, and `outValid` repeats `reqValid` with that same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Register select: 0 legacy, 1 extended |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Contents of the selected register |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Request physical address |
| reqSmm | input | 1 | Request issued in system-management mode |
| outValid | output | 1 | Decision valid |
| outRoute | output | 2 | 0 DRAM, 1 PCI, 2 blackhole |
| outAddr | output | 32 | Translated DRAM address |
| outData | output | 32 | Read data returned by the blackhole, all ones there, else 0 |

## Verification
The sweep runs every extended-register value against all four open and global-enable combinations, in both modes. Each combination is tried on addresses just inside and just outside every window edge and the top of low memory. The edge pairs separate off-by-one window limits. The mode and configuration grid separates the low and high alias choices and the size codes. Addresses inside a segment but outside a smaller one show whether the size code is honoured. A separate lock sequence checks that the open bit drops together with the lock, that writes to both registers are frozen afterwards, that the decode follows the forced-closed state, and that only reset releases the lock.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int SMM_AW = 32;

  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_PCI  = 2'd1,
    ROUTE_HOLE = 2'd2
  } route_e;

  // Strobes from the register control to the address datapath.
  typedef struct packed {
    logic              openWin;
    logic              highSel;
    logic              globalEn;
    logic [SMM_AW-1:0] tsegBytes;
  } smmCtl_t;
endpackage

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
#(
  parameter logic [7:0] LEG_MASK_OPEN = 8'h07,
  parameter logic [7:0] LEG_MASK_LOCK = 8'h00,
  parameter logic [7:0] EXT_MASK_OPEN = 8'h0F,
  parameter logic [7:0] EXT_MASK_LOCK = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output smmCtl_t    ctl
);
  localparam int B_OPEN = 0;
  localparam int B_LOCK = 1;
  localparam int B_GLOB = 2;
  localparam int B_HIGH = 0;
  localparam int B_SZLO = 1;
  localparam int B_TEN  = 3;
  localparam logic [SMM_AW-1:0] MIB = 32'h0010_0000;

  logic [7:0] legReg, extReg, legNext, extNext;
  logic [7:0] legMask, extMask;
  logic       lockNow;

  assign lockNow = legReg[B_LOCK];
  assign legMask = lockNow ? LEG_MASK_LOCK : LEG_MASK_OPEN;
  assign extMask = lockNow ? EXT_MASK_LOCK : EXT_MASK_OPEN;

  always_comb begin
    legNext = legReg;
    extNext = extReg;
    if (wrEn && !wrSel) legNext = (legReg & ~legMask) | (wrData & legMask);
    if (wrEn && wrSel)  extNext = (extReg & ~extMask) | (wrData & extMask);
    if (legNext[B_LOCK]) legNext[B_OPEN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      legReg <= 8'h00;
      extReg <= 8'h00;
    end else begin
      legReg <= legNext;
      extReg <= extNext;
    end
  end

  function automatic logic [SMM_AW-1:0] segSize(input logic en, input logic [1:0] code);
    if (!en) return '0;
    case (code)
      2'd0:    return MIB;
      2'd1:    return MIB << 1;
      2'd2:    return MIB << 3;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    ctl.openWin   = legReg[B_OPEN];
    ctl.globalEn  = legReg[B_GLOB];
    ctl.highSel   = extReg[B_HIGH];
    ctl.tsegBytes = segSize(extReg[B_TEN], extReg[B_SZLO+1:B_SZLO]);
  end

  assign rdData = wrSel ? extReg : legReg;

  // R3: lock stays set until reset
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    lockNow |=> lockNow);
  // R3: the open bit is never seen together with the lock
  p_lock_closes_r3: assert property (@(posedge clk) disable iff (!rstN)
    lockNow |-> !legReg[B_OPEN]);
  // R3: both registers are frozen once locked
  p_lock_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    lockNow |=> ($stable(legReg) && $stable(extReg)));
endmodule

// File: rtl/smm_path.sv
module smm_path
  import smm_pkg::*;
#(
  parameter logic [SMM_AW-1:0] TOP_LOW   = 32'h8000_0000,
  parameter logic [SMM_AW-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [SMM_AW-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [SMM_AW-1:0] WIN_BYTES = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  smmCtl_t           ctl,
  input  logic              reqValid,
  input  logic [SMM_AW-1:0] reqAddr,
  input  logic              reqSmm,
  output logic              outValid,
  output logic [1:0]        outRoute,
  output logic [SMM_AW-1:0] outAddr,
  output logic [SMM_AW-1:0] outData
);
  localparam logic [SMM_AW-1:0] LOW_END  = LOW_BASE + WIN_BYTES;
  localparam logic [SMM_AW-1:0] HIGH_END = HIGH_BASE + WIN_BYTES;

  logic              inLow, inHigh, inSeg, lowDram, highDram;
  logic [SMM_AW-1:0] segBase;
  route_e            nxtRoute;
  logic [SMM_AW-1:0] nxtAddr;

  assign segBase = TOP_LOW - ctl.tsegBytes;
  assign inLow   = (reqAddr >= LOW_BASE) && (reqAddr < LOW_END);
  assign inHigh  = (reqAddr >= HIGH_BASE) && (reqAddr < HIGH_END);
  assign inSeg   = (ctl.tsegBytes != '0) && (reqAddr >= segBase) && (reqAddr < TOP_LOW);

  always_comb begin
    if (reqSmm) begin
      lowDram  = !ctl.highSel && (ctl.globalEn || ctl.openWin);
      highDram =  ctl.highSel && (ctl.globalEn || ctl.openWin);
    end else begin
      lowDram  = !ctl.highSel && ctl.openWin;
      highDram =  ctl.highSel && ctl.openWin;
    end
  end

  always_comb begin
    nxtAddr = reqAddr;
    if (inLow) begin
      nxtRoute = lowDram ? ROUTE_DRAM : ROUTE_PCI;
    end else if (inHigh && highDram) begin
      nxtRoute = ROUTE_DRAM;
      nxtAddr  = reqAddr - HIGH_BASE + LOW_BASE;
    end else if (inSeg) begin
      nxtRoute = reqSmm ? ROUTE_DRAM : ROUTE_HOLE;
    end else begin
      nxtRoute = (reqAddr < TOP_LOW) ? ROUTE_DRAM : ROUTE_PCI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRoute <= ROUTE_DRAM;
      outAddr  <= '0;
      outData  <= '0;
    end else begin
      outValid <= reqValid;
      outRoute <= nxtRoute;
      outAddr  <= nxtAddr;
      outData  <= (nxtRoute == ROUTE_HOLE) ? '1 : '0;
    end
  end

  // R10: one cycle from request to decision
  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  // R8: only normal-mode requests below the top of low memory are blackholed
  p_hole_scope_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRoute == ROUTE_HOLE) |-> (!$past(reqSmm) && $past(reqAddr) < TOP_LOW));
  // R9: no unused route code ever leaves the block
  p_route_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outRoute != 2'd3));
endmodule

// File: rtl/smm_mem_router.sv
module smm_mem_router
  import smm_pkg::*;
#(
  parameter logic [31:0] TOP_LOW = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  cfgRdData,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqSmm,
  output logic        outValid,
  output logic [1:0]  outRoute,
  output logic [31:0] outAddr,
  output logic [31:0] outData
);
  smmCtl_t ctl;

  smm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrSel(cfgSel),
    .wrData(cfgWrData), .rdData(cfgRdData), .ctl(ctl)
  );

  smm_path #(.TOP_LOW(TOP_LOW)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqSmm(reqSmm), .outValid(outValid),
    .outRoute(outRoute), .outAddr(outAddr), .outData(outData)
  );
endmodule

// File: tb/tb_smm_mem_router.sv
module tb_smm_mem_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOPL = 32'h8000_0000;
  localparam logic [31:0] MB = 32'h0010_0000;

  logic        clk = 0, rstN = 0;
  logic        cfgWrEn = 0, cfgSel = 0;
  logic [7:0]  cfgWrData = 0, cfgRdData;
  logic        reqValid = 0, reqSmm = 0;
  logic [31:0] reqAddr = 0;
  logic        outValid;
  logic [1:0]  outRoute;
  logic [31:0] outAddr, outData;

  int total = 0, bad = 0;
  bit finished = 0;

  smm_mem_router dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1; cfgSel = sel; cfgWrData = d;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic cfgRead(input logic sel, input logic [7:0] exp, input string req);
    @(negedge clk); cfgSel = sel; #1;
    chk(req, {24'h0, cfgRdData}, {24'h0, exp});
  endtask

  task automatic model(input logic [31:0] a, input logic smm, input logic op, input logic ge,
                       input logic [7:0] ext, output logic [1:0] r, output logic [31:0] da);
    logic hs, lowOk, highOk; logic [31:0] sz;
    hs = ext[0];
    sz = !ext[3] ? 0 : (ext[2:1] == 0) ? MB : (ext[2:1] == 1) ? 2*MB : (ext[2:1] == 2) ? 8*MB : 0;
    lowOk  = !hs && (op || (smm && ge));
    highOk =  hs && (op || (smm && ge));
    da = a;
    if (a >= 32'hA0000 && a <= 32'hBFFFF) r = lowOk ? 2'd0 : 2'd1;
    else if (a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF && highOk) begin r = 0; da = a - 32'hFED00000; end
    else if (sz != 0 && a >= TOPL - sz && a < TOPL) r = smm ? 2'd0 : 2'd2;
    else r = (a < TOPL) ? 2'd0 : 2'd1;
  endtask

  task automatic access(input logic [31:0] a, input logic smm, input logic op, input logic ge,
                        input logic [7:0] ext, input string req);
    logic [1:0] r; logic [31:0] da;
    model(a, smm, op, ge, ext, r, da);
    @(negedge clk); reqValid = 1; reqAddr = a; reqSmm = smm;
    @(negedge clk); reqValid = 0;
    chk({req, " valid R10"}, {31'h0, outValid}, 32'd1);
    chk({req, " route"}, {30'h0, outRoute}, {30'h0, r});
    if (r == 0) chk({req, " addr"}, outAddr, da);
    chk({req, " data"}, outData, (r == 2) ? 32'hFFFFFFFF : 32'h0);
  endtask

  function automatic string tagFor(input logic [31:0] a);
    if (a >= 32'hA0000 && a <= 32'hBFFFF) return "R4 R6 low";
    if (a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF) return "R5 R6 high";
    if (a >= TOPL - 8*MB && a < TOPL) return "R7 R8 seg";
    return "R9 plain";
  endfunction

  logic [31:0] addrs [15];
  initial begin
    addrs = '{32'h100, 32'h9FFFF, 32'hA0000, 32'hBFFFF, 32'hC0000,
              32'hFED9FFFF, 32'hFEDA0000, 32'hFEDBFFFF, 32'hFEDC0000,
              TOPL - 8*MB - 1, TOPL - 8*MB, TOPL - 2*MB, TOPL - MB, TOPL - 1, TOPL};
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outValid", {31'h0, outValid}, 0);
    cfgRead(0, 8'h00, "R1 legacy");
    cfgRead(1, 8'h00, "R1 extended");
    rstN = 1;
    // R2 writable fields and reserved bits
    cfgWrite(0, 8'hFD); cfgRead(0, 8'h05, "R2 legacy mask");
    cfgWrite(1, 8'hFF); cfgRead(1, 8'h0F, "R2 extended mask");
    // R10 idle cycle
    @(negedge clk); chk("R10 idle", {31'h0, outValid}, 0);
    // sweep
    for (int e = 0; e < 16; e++) begin
      cfgWrite(1, 8'(e));
      for (int g = 0; g < 4; g++) begin
        cfgWrite(0, {5'b0, g[1], 1'b0, g[0]});
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 15; k++)
            access(addrs[k], s[0], g[0], g[1], 8'(e), tagFor(addrs[k]));
      end
    end
    // R3 lock
    cfgWrite(0, 8'h05); cfgWrite(1, 8'h08);
    cfgWrite(0, 8'h07); cfgRead(0, 8'h06, "R3 lock clears open");
    cfgWrite(0, 8'h01); cfgRead(0, 8'h06, "R3 legacy frozen");
    cfgWrite(1, 8'h00); cfgRead(1, 8'h08, "R3 extended frozen");
    access(32'hA0000, 0, 0, 1, 8'h08, "R3 closed low");
    access(TOPL - 1, 0, 0, 1, 8'h08, "R3 seg kept");
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1;
    cfgRead(0, 8'h00, "R3 reset unlocks");
    cfgWrite(0, 8'h01); cfgRead(0, 8'h01, "R3 writable after reset");
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin repeat (150000) @(posedge clk); total++; bad++; $display("FAIL watchdog expired"); end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule